// File: doc/BRIEF.md
# Periodic Micro-Frame Slot Selector

This block decides, for a single periodic schedule entry, whether that entry may run a transaction in the current micro-frame and which kind it would be. It keeps a 14-bit frame index that advances on every micro-frame tick. The three low bits of that index pick one of eight micro-frame slots. Each entry carries a 16-bit capability word that holds two 8-bit slot masks. The start mask marks the slots in which the entry may start work. The completion mask marks the slots in which a low- or full-speed split transaction may be completed.

The selector combines the chosen mask bits with the endpoint speed code, the active flag, the split-pending flag and the schedule membership flag. From these it raises at most one of three registered candidate outputs: a normal high-speed transaction, a start-split or a complete-split. A zero mask in a position where the result would otherwise be undefined raises an error flag and blocks every candidate. The same happens when a start mask is non-zero on an entry that sits on the asynchronous schedule.

Top module: `uframe_slot_sel`

## Requirements
- R1: `frame_idx` resets to 0. It increases by 1 on each clock edge at which `uframe_tick` is 1, wraps from 16383 to 0, and holds its value when `uframe_tick` is 0.
- R2: The micro-frame slot is `frame_idx[2:0]`. Slot n selects bit n of the start mask `cap_word[7:0]` and bit 8+n of `cap_word` (bit n of the completion mask `cap_word[15:8]`).
- R3: All four outputs `cand_normal`, `cand_ssplit`, `cand_csplit` and `mask_err` are registered. Each reflects the `frame_idx` value and the inputs present before the previous clock edge. All four are 0 in reset.
- R4: `cand_normal` is 1 when all of the following hold: the entry is periodic, the speed is high (`speed` 2'b10; 2'b11 is also treated as high speed), `entry_active` is 1, the selected start-mask bit is 1, and there is no error.
- R5: `cand_ssplit` is 1 when all of the following hold: the entry is periodic, `speed` is 2'b00 (full) or 2'b01 (low), `entry_active` is 1, `split_pending` is 0, the selected start-mask bit is 1, and there is no error.
- R6: `cand_csplit` is 1 when all of the following hold: the entry is periodic, the speed is low or full, `entry_active` is 1, `split_pending` is 1, the selected completion-mask bit is 1, and there is no error.
- R7: For a high-speed entry the completion mask has no effect on any output, including `mask_err`.
- R8: An entry with `on_periodic` equal to 0 never produces a candidate. Such an entry raises `mask_err` when its start mask is non-zero.
- R9: A periodic entry raises `mask_err` and produces no candidate in either of two cases: its start mask is zero, or it is low or full speed and its completion mask is zero.
- R10: At most one candidate output is 1 in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| uframe_tick | input | 1 | Advances the frame index by one |
| cap_word | input | 16 | Completion mask [15:8], start mask [7:0] |
| speed | input | 2 | 00 full, 01 low, 10 high speed |
| entry_active | input | 1 | Entry holds an active transfer |
| split_pending | input | 1 | A start-split is done; completion outstanding |
| on_periodic | input | 1 | 1 periodic schedule, 0 asynchronous |
| frame_idx | output | 14 | Frame index counter |
| cand_normal | output | 1 | High-speed transaction candidate |
| cand_ssplit | output | 1 | Start-split candidate |
| cand_csplit | output | 1 | Complete-split candidate |
| mask_err | output | 1 | Undefined mask configuration detected |

## Verification
The case that is hardest to reach from the ports is the counter wrap. The test must hold `uframe_tick` high for more than sixteen thousand cycles, and during that run the wrap from 16383 to 0 must land in slot 0 while a real mask pattern is applied. The bench therefore ticks on every cycle through a full period and keeps a split entry with known masks applied, so that the candidate behaviour is checked across the wrap as well as at the index value. The error cases are reached with directed mask words: a zero start mask, a zero completion mask at full speed and at high speed, and a non-zero start mask on the asynchronous schedule. These are followed by a long pseudo-random sweep of every input.

// File: rtl/uslot_pkg.sv
package uslot_pkg;
    localparam logic [1:0] SPD_FULL = 2'b00;
    localparam logic [1:0] SPD_LOW  = 2'b01;
    localparam logic [1:0] SPD_HIGH = 2'b10;

    typedef struct packed {
        logic normal;
        logic ssplit;
        logic csplit;
        logic err;
    } cand_t;
endpackage

// File: rtl/uframe_idx_ctr.sv
module uframe_idx_ctr #(
    parameter int IDX_W = 14
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    output logic [IDX_W-1:0] idx_o
);
    localparam logic [IDX_W-1:0] IDX_MAX = '1;

    logic [IDX_W-1:0] idx_d, idx_q;

    always_comb begin
        idx_d = idx_q;
        if (tick) idx_d = idx_q + IDX_W'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n) idx_q <= '0;
        else        idx_q <= idx_d;
    end

    assign idx_o = idx_q;

    // R1
    idx_wrap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (tick && idx_q == IDX_MAX) |=> (idx_q == '0));
    // R1
    idx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> $stable(idx_q));
endmodule

// File: rtl/uframe_mask_pick.sv
module uframe_mask_pick #(
    parameter int UF_BITS = 3
) (
    input  logic [(1<<UF_BITS)-1:0] mask_i,
    input  logic [UF_BITS-1:0]      slot_i,
    output logic                    hit_o,
    output logic                    zero_o
);
    always_comb begin
        hit_o  = mask_i[slot_i];
        zero_o = (mask_i == '0);
    end
endmodule

// File: rtl/uframe_slot_sel.sv
module uframe_slot_sel
    import uslot_pkg::*;
#(
    parameter int IDX_W   = 14,
    parameter int UF_BITS = 3
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           uframe_tick,
    input  logic [2*(1<<UF_BITS)-1:0]      cap_word,
    input  logic [1:0]                     speed,
    input  logic                           entry_active,
    input  logic                           split_pending,
    input  logic                           on_periodic,
    output logic [IDX_W-1:0]               frame_idx,
    output logic                           cand_normal,
    output logic                           cand_ssplit,
    output logic                           cand_csplit,
    output logic                           mask_err
);
    localparam int MASK_W = 1 << UF_BITS;

    logic [IDX_W-1:0] idx;
    logic             s_hit, s_zero, c_hit, c_zero, slow;
    cand_t            cand_d, cand_q;

    uframe_idx_ctr #(.IDX_W(IDX_W)) ctr_i (
        .clk   (clk),
        .rst_n (rst_n),
        .tick  (uframe_tick),
        .idx_o (idx)
    );

    uframe_mask_pick #(.UF_BITS(UF_BITS)) smask_i (
        .mask_i (cap_word[MASK_W-1:0]),
        .slot_i (idx[UF_BITS-1:0]),
        .hit_o  (s_hit),
        .zero_o (s_zero)
    );

    uframe_mask_pick #(.UF_BITS(UF_BITS)) cmask_i (
        .mask_i (cap_word[2*MASK_W-1:MASK_W]),
        .slot_i (idx[UF_BITS-1:0]),
        .hit_o  (c_hit),
        .zero_o (c_zero)
    );

    always_comb begin
        slow   = (speed == SPD_FULL) || (speed == SPD_LOW);
        cand_d = '0;
        if (on_periodic) begin
            cand_d.err = s_zero || (slow && c_zero);
        end else begin
            cand_d.err = !s_zero;
        end
        if (on_periodic && !cand_d.err && entry_active) begin
            if (!slow) begin
                cand_d.normal = s_hit;
            end else if (split_pending) begin
                cand_d.csplit = c_hit;
            end else begin
                cand_d.ssplit = s_hit;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cand_q <= '0;
        else        cand_q <= cand_d;
    end

    assign frame_idx   = idx;
    assign cand_normal = cand_q.normal;
    assign cand_ssplit = cand_q.ssplit;
    assign cand_csplit = cand_q.csplit;
    assign mask_err    = cand_q.err;

    // R10
    one_cand_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cand_q.normal, cand_q.ssplit, cand_q.csplit}));
    // R8
    async_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cand_d.normal || cand_d.ssplit || cand_d.csplit) |=> $past(on_periodic));
    // R6
    csplit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_d.csplit |=> (cand_csplit && $past(split_pending) && $past(entry_active)));
    // R5
    ssplit_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cand_d.ssplit |=> !$past(split_pending));
    // R9
    err_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mask_err |-> !(cand_normal || cand_ssplit || cand_csplit));
endmodule

// File: tb/uframe_slot_sel_tb_top.sv
module uframe_slot_sel_tb_top;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        uframe_tick = 1'b0;
    logic [15:0] cap_word = '0;
    logic [1:0]  speed = 2'b00;
    logic        entry_active = 1'b0;
    logic        split_pending = 1'b0;
    logic        on_periodic = 1'b0;
    logic [13:0] frame_idx;
    logic        cand_normal, cand_ssplit, cand_csplit, mask_err;

    int checks = 0;
    int fails  = 0;
    int cycles = 0;
    bit done   = 1'b0;

    int m_idx = 0;
    bit e_n = 0, e_s = 0, e_c = 0, e_e = 0;

    always #4 clk = ~clk;

    uframe_slot_sel dut_i (
        .clk(clk), .rst_n(rst_n), .uframe_tick(uframe_tick), .cap_word(cap_word),
        .speed(speed), .entry_active(entry_active), .split_pending(split_pending),
        .on_periodic(on_periodic), .frame_idx(frame_idx), .cand_normal(cand_normal),
        .cand_ssplit(cand_ssplit), .cand_csplit(cand_csplit), .mask_err(mask_err)
    );

    // behavioural reference, advanced on the same edge as the design
    always @(posedge clk) begin
        if (!rst_n) begin
            m_idx <= 0;
            e_n <= 0; e_s <= 0; e_c <= 0; e_e <= 0;
        end else begin
            int slot;
            bit slowspd, sb, cb, er;
            slot    = m_idx % 8;
            slowspd = (speed < 2);
            sb      = cap_word[slot];
            cb      = cap_word[8 + slot];
            if (on_periodic) er = (cap_word[7:0] == 0) || (slowspd && cap_word[15:8] == 0);
            else             er = (cap_word[7:0] != 0);
            e_e <= er;
            e_n <= on_periodic && !er && entry_active && !slowspd && sb;
            e_s <= on_periodic && !er && entry_active && slowspd && !split_pending && sb;
            e_c <= on_periodic && !er && entry_active && slowspd && split_pending && cb;
            if (uframe_tick) m_idx <= (m_idx + 1) % 16384;
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s actual=%0d expected=%0d at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        cycles++;
        if (!done) begin
            chk("R1 frame_idx", frame_idx, m_idx);
            chk("R2 R3 R4 R7 cand_normal", cand_normal, e_n);
            chk("R2 R3 R5 cand_ssplit", cand_ssplit, e_s);
            chk("R2 R3 R6 cand_csplit", cand_csplit, e_c);
            chk("R3 R8 R9 mask_err", mask_err, e_e);
            chk("R10 single candidate", int'(cand_normal) + int'(cand_ssplit) + int'(cand_csplit) <= 1, 1);
        end
    end

    task automatic run(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic setup(input logic tk, input logic [15:0] cw, input logic [1:0] sp,
                         input logic ac, input logic spl, input logic per);
        uframe_tick = tk; cap_word = cw; speed = sp;
        entry_active = ac; split_pending = spl; on_periodic = per;
    endtask

    initial begin
        run(3);
        // R3: reset state
        chk("R3 reset normal", cand_normal, 0);
        chk("R3 reset err", mask_err, 0);
        chk("R1 reset idx", frame_idx, 0);
        rst_n = 1'b1;
        // R1 hold without tick
        setup(0, 16'h0101, 2'b10, 1, 0, 1);
        run(4);
        chk("R1 hold", frame_idx, 0);
        // R4 high-speed, sparse start mask
        setup(1, 16'h0005, 2'b10, 1, 0, 1);
        run(20);
        // R7 completion mask changes with high speed
        setup(1, 16'hA5C3, 2'b10, 1, 0, 1);
        run(16);
        setup(1, 16'h0081, 2'b11, 1, 0, 1);
        run(16);
        // R5/R6 full speed start then complete
        setup(1, 16'h1C01, 2'b00, 1, 0, 1);
        run(16);
        setup(1, 16'h1C01, 2'b00, 1, 1, 1);
        run(16);
        // low speed, inactive then active
        setup(1, 16'hE007, 2'b01, 0, 1, 1);
        run(10);
        setup(1, 16'hE007, 2'b01, 1, 1, 1);
        run(16);
        // R9 zero masks
        setup(1, 16'hFF00, 2'b10, 1, 0, 1);
        run(8);
        setup(1, 16'h00FF, 2'b00, 1, 1, 1);
        run(8);
        chk("R9 zero completion mask", mask_err, 1);
        // R7 zero completion at high speed is legal
        setup(1, 16'h00FF, 2'b10, 1, 0, 1);
        run(8);
        chk("R7 high speed ignores completion mask", mask_err, 0);
        // R8 asynchronous schedule
        setup(1, 16'hFF00, 2'b00, 1, 1, 0);
        run(8);
        setup(1, 16'h0001, 2'b10, 1, 0, 0);
        run(8);
        chk("R8 async non-zero start mask", mask_err, 1);
        // pseudo-random sweep
        for (int i = 0; i < 4000; i++) begin
            logic [31:0] r;
            r = $urandom;
            setup(r[0], r[31:16], r[2:1], r[3] | r[4], r[5], r[6] | r[7]);
            run(1);
        end
        // R1 wrap with continuous ticking over a full period
        setup(1, 16'h3C81, 2'b00, 1, 1, 1);
        run(16400);
        setup(1, 16'h3C81, 2'b00, 1, 0, 1);
        run(16400);
        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        #(8 * 150000);
        if (!done) begin
            done = 1'b1;
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=%0d expected=%0d", cycles, 0);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule